// File: doc/BRIEF.md
# Redundant-Weight Successive-Approximation Sequencer

This block is the digital half of a successive-approximation converter whose step sizes do not have to be powers of two. A start pulse begins a conversion. The block then drives a reference code to an external DAC and reads one comparator bit per cycle. After each reading it moves the reference up or down by the next entry of a weight table. After the last step it turns the recorded decisions into an N-bit binary result.

The weight table is a parameter, so the same logic serves a Fibonacci-like, a silver-ratio-like or a plain binary weight set. When the table has redundancy (the later weights add up to more than is strictly needed), a wrong comparator decision near a reference level is absorbed by the later steps. The result is then still correct. The result is the final reference level corrected by half an LSB in the direction of the last decision. It is not the decision bits copied into result bits.

A weight table whose first entry is not 2^(N-1) is rejected when the design is elaborated. So is a table in which some weight is larger than one plus the sum of all the weights after it.

Top module: `sar_redund_top`

## Requirements
- R1: After reset, busy and done are 0, and result, decBits and dacCode are all 0.
- R2: A start pulse while idle makes busy high for exactly M cycles. done is a one-cycle pulse in the first cycle in which busy is low again, and result is valid from that cycle.
- R3: A start pulse while busy is ignored. The running conversion keeps its M-cycle length and its result, and no second conversion follows.
- R4: In the first busy cycle, dacCode equals 2^(N-1) (16 for N = 5).
- R5: The comparator is sampled at the clock edge that ends each busy cycle. dacCode in the next cycle is the previous level plus the next weight if the sample was 1 (input above the reference), and minus that weight if it was 0.
- R6: decBits holds the decisions of the last conversion with the first decision in bit M-1 and the last decision in bit 0. A new start clears it.
- R7: result equals the final reference level plus d(M) − 1. With weights 16,10,6,3,2,1 and an input of 6.3 this gives decisions 010001 and result 6. With weights 16,8,4,2,1 and an input of 7.3 it gives 00111 and 7. With weights 16,4,4,2,2,1,1,1 and an input of 6.3 it gives 00010010 and 6.
- R8: A single wrong decision at a level within the redundancy margin still gives the correct result. For an input of 6.3, a wrong 0 at level 6 gives 001111 and result 6. For an input of 20.5, a wrong 0 at level 20 gives 100111 and result 20.
- R9: dacCode is the internal level clamped to the range 0 to 2^N − 1. For example, an internal level of 32 is driven as 31 and a negative level is driven as 0.
- R10: result saturates to the range 0 to 2^N − 1. All-ones decisions (sum 38) give 31, and all-zeros decisions (−7) give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when idle |
| cmpIn | input | 1 | Comparator decision, 1 when the input is above the reference |
| busy | output | 1 | High while the steps run |
| done | output | 1 | One-cycle pulse when result updates |
| dacCode | output | N | Clamped reference code for the DAC |
| decBits | output | M | Decisions of the last conversion, first decision in the MSB |
| result | output | N | Saturated binary result |

## Verification
The hardest situation to reach is a comparator decision that is wrong while the remaining weights can still pull the level back. An ideal comparator never makes such a decision. The bench therefore models the comparator from dacCode and a scaled input value, and inverts its answer at one chosen step index, counted from the start of the conversion. The same bench drives inputs beyond full scale and at zero, so that the internal level leaves the DAC range and both the clamp and the result saturation are exercised.

// File: rtl/sar_redund_pkg.sv
package sar_redund_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // begin a conversion: set first level, clear decisions
    logic sample;  // capture cmpIn at this edge
    logic last;    // this sample is the final step
  } sarStrobe_t;
endpackage

// File: rtl/sar_redund_ctrl.sv
module sar_redund_ctrl
  import sar_redund_pkg::*;
#(
  parameter int M = 6,
  localparam int SW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] stepIdx,
  output sarStrobe_t    strobe
);
  localparam logic [SW-1:0] LAST = SW'(M - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepIdx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          stepIdx <= '0;
        end
      end else if (stepIdx == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load   = start && !busy;
    strobe.sample = busy;
    strobe.last   = busy && (stepIdx == LAST);
  end

  // R2: done is a single pulse that follows the end of busy
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R3: a running conversion advances one step per cycle, whatever start does
  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepIdx != LAST) |=> (busy && stepIdx == $past(stepIdx) + 1'b1));
endmodule

// File: rtl/sar_redund_dp.sv
module sar_redund_dp
  import sar_redund_pkg::*;
#(
  parameter int N = 5,
  parameter int M = 6,
  parameter int WBITS = 8,
  parameter logic [M*WBITS-1:0] WEIGHTS = {8'd16, 8'd10, 8'd6, 8'd3, 8'd2, 8'd1},
  localparam int SW = (M > 1) ? $clog2(M) : 1,
  localparam int RW = WBITS + $clog2(M + 1) + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  sarStrobe_t    strobe,
  input  logic [SW-1:0] stepIdx,
  input  logic          cmpIn,
  output logic [N-1:0]  dacCode,
  output logic [M-1:0]  decBits,
  output logic [N-1:0]  result
);
  localparam logic signed [RW-1:0] FIRST = RW'(1 << (N - 1));
  localparam logic signed [RW-1:0] TOP   = RW'((1 << N) - 1);

  function automatic int wAt(int k);
    return int'(WEIGHTS[(M - 1 - k) * WBITS +: WBITS]);
  endfunction

  // First weight must be half scale; each weight at most one above the tail sum
  function automatic bit tableOk();
    int tail = 0;
    bit ok = (wAt(0) == (1 << (N - 1)));
    for (int k = M - 1; k >= 0; k--) begin
      if (tail < wAt(k) - 1) ok = 1'b0;
      if (wAt(k) <= 0) ok = 1'b0;
      tail += wAt(k);
    end
    return ok;
  endfunction

  generate
    if (!tableOk()) begin : g_badTable
      $error("weight table lacks the redundancy needed for correction");
    end
  endgenerate

  function automatic logic [N-1:0] clampN(logic signed [RW-1:0] v);
    if (v < 0) return '0;
    else if (v > TOP) return '1;
    else return v[N-1:0];
  endfunction

  logic signed [RW-1:0] refLvl;
  logic signed [RW-1:0] nextW;
  logic signed [RW-1:0] finalLvl;

  // Weight of the step after the current one
  always_comb begin
    nextW = '0;
    for (int i = 1; i < M; i++) begin
      if (int'(stepIdx) + 1 == i) nextW = RW'(wAt(i));
    end
  end

  assign finalLvl = cmpIn ? refLvl : refLvl - RW'(1);
  assign dacCode  = clampN(refLvl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refLvl  <= '0;
      decBits <= '0;
      result  <= '0;
    end else if (strobe.load) begin
      refLvl  <= FIRST;
      decBits <= '0;
    end else if (strobe.sample) begin
      decBits <= {decBits[M-2:0], cmpIn};
      if (strobe.last) result <= clampN(finalLvl);
      else if (cmpIn)  refLvl <= refLvl + nextW;
      else             refLvl <= refLvl - nextW;
    end
  end

  // R4: a conversion starts at half scale
  p_first_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (dacCode == N'(1 << (N - 1)) && decBits == '0));
  // R5: the level moves in the direction of the decision
  p_move_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && !strobe.last && cmpIn) |=> (refLvl > $past(refLvl)));
  p_move_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && !strobe.last && !cmpIn) |=> (refLvl < $past(refLvl)));
  // R7: result changes only at the final step
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.sample && strobe.last) |=> $stable(result));
endmodule

// File: rtl/sar_redund_top.sv
module sar_redund_top
  import sar_redund_pkg::*;
#(
  parameter int N = 5,
  parameter int M = 6,
  parameter int WBITS = 8,
  parameter logic [M*WBITS-1:0] WEIGHTS = {8'd16, 8'd10, 8'd6, 8'd3, 8'd2, 8'd1}
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cmpIn,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] dacCode,
  output logic [M-1:0] decBits,
  output logic [N-1:0] result
);
  localparam int SW = (M > 1) ? $clog2(M) : 1;

  sarStrobe_t    strobe;
  logic [SW-1:0] stepIdx;

  sar_redund_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .busy(busy), .done(done), .stepIdx(stepIdx), .strobe(strobe)
  );

  sar_redund_dp #(.N(N), .M(M), .WBITS(WBITS), .WEIGHTS(WEIGHTS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx), .cmpIn(cmpIn),
    .dacCode(dacCode), .decBits(decBits), .result(result)
  );
endmodule

// File: tb/sar_redund_top_bench.sv
module sar_redund_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // Main instance: weights 16,10,6,3,2,1
  logic start = 1'b0;
  logic cmpMain;
  logic busy, done;
  logic [4:0] dac, res;
  logic [5:0] dec;
  int vinMain = 0;   // input voltage times ten
  int curStep = -1;  // step index of the current busy cycle
  int flipStep = -1; // step at which the comparator lies

  assign cmpMain = (vinMain > int'(dac) * 10) ^ (curStep == flipStep);

  sar_redund_top u_sar_redund_top (
    .clk(clk), .rstN(rstN), .start(start), .cmpIn(cmpMain),
    .busy(busy), .done(done), .dacCode(dac), .decBits(dec), .result(res)
  );

  // Binary and silver-ratio variants with ideal comparators
  logic startAux = 1'b0;
  logic busyB, doneB, busyS, doneS, cmpB, cmpS;
  logic [4:0] dacB, resB, dacS, resS;
  logic [4:0] decB;
  logic [7:0] decS;
  int vinAux = 0;
  assign cmpB = vinAux > int'(dacB) * 10;
  assign cmpS = vinAux > int'(dacS) * 10;

  sar_redund_top #(.N(5), .M(5), .WEIGHTS({8'd16, 8'd8, 8'd4, 8'd2, 8'd1})) u_sar_redund_top_bin (
    .clk(clk), .rstN(rstN), .start(startAux), .cmpIn(cmpB),
    .busy(busyB), .done(doneB), .dacCode(dacB), .decBits(decB), .result(resB)
  );
  sar_redund_top #(.N(5), .M(8),
    .WEIGHTS({8'd16, 8'd4, 8'd4, 8'd2, 8'd2, 8'd1, 8'd1, 8'd1})) u_sar_redund_top_sil (
    .clk(clk), .rstN(rstN), .start(startAux), .cmpIn(cmpS),
    .busy(busyS), .done(doneS), .dacCode(dacS), .decBits(decS), .result(resS)
  );

  localparam int NV = 8;
  localparam int VIN [NV]  = '{63, 63, 0, 400, 205, 115, 305, 205};
  localparam int FLIP[NV]  = '{-1, 1, -1, -1, -1, -1, -1, 2};
  localparam logic [5:0] EXPDEC[NV] = '{6'b010001, 6'b001111, 6'b000000, 6'b111111,
                                        6'b101001, 6'b010110, 6'b110101, 6'b100111};
  localparam int EXPRES[NV] = '{6, 6, 0, 31, 20, 11, 30, 20};

  int dacSeen[16];
  int busyCnt;
  logic doneAtEnd, doneAfter, busyAfter;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One conversion on the main instance; midStart pulses start while busy
  task automatic runMain(int vin, int flip, bit midStart);
    vinMain = vin;
    flipStep = flip;
    curStep = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    busyCnt = 0;
    curStep = 0;
    while (busy && busyCnt < 16) begin
      dacSeen[busyCnt] = int'(dac);
      start = (midStart && busyCnt == 2);
      @(negedge clk);
      busyCnt++;
      curStep = busyCnt;
    end
    start = 1'b0;
    curStep = -1;
    doneAtEnd = done;
    @(negedge clk);
    doneAfter = done;
    busyAfter = busy;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(res), 0);
    check("R1 decBits", int'(dec), 0);
    check("R1 dacCode", int'(dac), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runMain(VIN[i], FLIP[i], 1'b0);
      check("R2 busy length", busyCnt, 6);
      check("R2 done at end", int'(doneAtEnd), 1);
      check("R2 done one cycle", int'(doneAfter), 0);
      check("R4 first level", dacSeen[0], 16);
      check((FLIP[i] >= 0) ? "R8 decisions" : "R6 decisions", int'(dec), int'(EXPDEC[i]));
      check((FLIP[i] >= 0) ? "R8 result" : "R7 result", int'(res), EXPRES[i]);
      if (i == 0) begin
        check("R5 level after down", dacSeen[1], 6);
        check("R5 level after up", dacSeen[2], 12);
        check("R5 final level", dacSeen[5], 6);
      end
      if (i == 2) begin
        check("R9 negative level clamps to 0", dacSeen[3], 0);
        check("R10 result low saturation", int'(res), 0);
      end
      if (i == 3) begin
        check("R9 level 32 clamps to 31", dacSeen[2], 31);
        check("R10 result high saturation", int'(res), 31);
      end
      if (i == 7) check("R8 corrected level after wrong decision", dacSeen[3], 17);
    end

    // R3: start while busy is ignored
    runMain(115, -1, 1'b1);
    check("R3 busy length", busyCnt, 6);
    check("R3 result", int'(res), 11);
    check("R3 no second conversion", int'(busyAfter), 0);

    // R6: a new start clears decBits
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R6 cleared on start", int'(dec), 0);
    while (busy) @(negedge clk);
    @(negedge clk);

    // R7: binary and silver-ratio weight sets
    vinAux = 63;
    @(negedge clk) startAux = 1'b1;
    @(negedge clk) startAux = 1'b0;
    vinAux = 73;
    while (busyS) begin
      vinAux = busyB ? 73 : 63;
      @(negedge clk);
    end
    check("R7 silver decisions", int'(decS), 8'b00010010);
    check("R7 silver result", int'(resS), 6);
    check("R7 binary decisions", int'(decB), 5'b00111);
    check("R7 binary result", int'(resB), 7);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule